// File: doc/BRIEF.md
# Voice Recorder Serial Command Slave

This block is the serial front end of a message record/playback controller. A host microcontroller drives an SPI-mode link (active-low select, SCLK, MOSI, MISO). The block accepts either a short frame carrying only a control byte or a long frame carrying a 16-bit start address followed by the control byte. It splits the control byte into its run, play/record, power, ignore-address and cue fields and classifies the opcode. When select rises, it hands the result to a separate operation sequencer as a one-cycle strobe.

While a command is being shifted in, the block shifts status out on MISO: the pending overflow and end-of-message flags, then the sequencer's current row pointer. It also holds an active-low interrupt line that the sequencer raises through event pulses and that the start of any frame releases. All serial inputs are brought into the system clock domain, and edges are detected there. The system clock must run at least four times faster than SCLK.

Top module: `vrec_cmd_slave`

## Requirements
- R1: A frame starts when select falls. SCLK edges and MOSI while select is high have no effect. No strobe is issued and miso_oe stays 0.
- R2: A 24-bit frame carries the address bits A0..A15 first, least significant first. The control bits follow in the order RUN, PLAY, PWR, IAB, CUE, and the last three bits are ignored. The strobe reports cmd_addr = the address and cmd_has_addr = 1.
- R3: An 8-bit frame carries only the control bits, in the same order as in R2. The strobe reports cmd_has_addr = 0 and cmd_addr = 0.
- R4: A frame whose bit count at select rise is neither 8 nor 24 is discarded, and no strobe is issued.
- R5: cmd_kind encodes the opcode (written RUN PLAY PWR IAB CUE): 00100 = 1 (power up), 11100 = 2 (set play), 11110 = 3 (play), 10100 = 4 (set record), 10110 = 5 (record), 11101 = 6 (set cue), 11111 = 7 (cue), 0x110 = 8 (stop / read status), 0x01x = 9 (stop and power down), any other pattern = 15. cmd_run, cmd_play, cmd_pwr and cmd_ign_addr copy their bits.
- R6: cmd_cue is 1 only if CUE, RUN, PLAY and PWR are all 1. A cue request during record gives cmd_cue = 0 and kind 15.
- R7: cmd_valid is a single-cycle pulse issued only after select rises, never while a frame is in progress.
- R8: MISO presents the overflow flag, then the end-of-message flag, then row_ptr bits 0..15, and 0 after that. The first bit is valid before the first rising SCLK edge, and each later bit follows a falling edge. The flags and row_ptr are captured when select falls.
- R9: miso_oe is 1 while select is low and 0 while it is high.
- R10: An evt_ovf or evt_eom pulse drives int_n low on the next cycle. int_n stays low until a frame starts, which releases it. An event in the same cycle as the frame start wins.
- R11: After reset, int_n = 1, miso_oe = 0, miso = 0 and cmd_valid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ss_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock from host |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial status data to host |
| miso_oe | output | 1 | Output enable for the MISO driver |
| int_n | output | 1 | Interrupt, active low (open-drain style) |
| evt_ovf | input | 1 | Overflow event pulse from sequencer |
| evt_eom | input | 1 | End-of-message event pulse from sequencer |
| row_ptr | input | 16 | Current row pointer from sequencer |
| cmd_valid | output | 1 | One-cycle decoded command strobe |
| cmd_kind | output | 4 | Opcode class, encoding per R5 |
| cmd_run | output | 1 | Start (1) / stop (0) bit |
| cmd_play | output | 1 | Play (1) / record (0) bit |
| cmd_pwr | output | 1 | Power up (1) / down (0) bit |
| cmd_ign_addr | output | 1 | Continue from current address |
| cmd_cue | output | 1 | Message cueing, qualified per R6 |
| cmd_has_addr | output | 1 | Frame carried an address |
| cmd_addr | output | 16 | Start address from a long frame |

## Verification
The hardest situation to reach is an interrupt that is pending when a frame begins. The flags must be captured into the outgoing status before the release clears them, and int_n must already read high at the first bit. The bench pulses an event, checks that int_n holds low across idle cycles, and then starts a frame. It expects the flag in the first MISO bits and int_n high at the first sample point. Malformed frames of 1, 12, 23 and 25 bits, and SCLK toggling while the block is deselected, are mixed in between valid commands. The strobe queue must stay aligned with the valid commands throughout.

// File: rtl/vrec_pkg.sv
package vrec_pkg;
  localparam int NCTRL = 5;

  typedef enum logic [3:0] {
    K_NONE    = 4'd0,
    K_PWRUP   = 4'd1,
    K_SETPLAY = 4'd2,
    K_PLAY    = 4'd3,
    K_SETREC  = 4'd4,
    K_REC     = 4'd5,
    K_SETCUE  = 4'd6,
    K_CUE     = 4'd7,
    K_STOP    = 4'd8,
    K_STOPPD  = 4'd9,
    K_OTHER   = 4'd15
  } cmd_kind_e;

  // run is bit 0: it is the first control bit on the wire
  typedef struct packed {
    logic mc;
    logic iab;
    logic pu;
    logic pr;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/vrec_sync.sv
module vrec_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES*W-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[(STAGES-1)*W-1:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES*W-1 -: W];
endmodule

// File: rtl/vrec_frame.sv
module vrec_frame #(
  parameter int ADDR_W = 16,
  parameter int CTRL_W = 8,
  localparam int LONG_W = ADDR_W + CTRL_W,
  localparam int CNT_W  = $clog2(LONG_W) + 1,
  localparam int KEEP_W = ADDR_W + vrec_pkg::NCTRL
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ss_s,
  input  logic              sclk_s,
  input  logic              mosi_s,
  input  logic [ADDR_W+1:0] status_in,
  output logic              frame_start,
  output logic              frame_end,
  output logic [KEEP_W-1:0] frame_bits,
  output logic [CNT_W-1:0]  frame_len,
  output logic              miso,
  output logic              miso_oe
);
  localparam int IDX_W = $clog2(KEEP_W);
  localparam logic [CNT_W-1:0] KEEP_C  = CNT_W'(KEEP_W);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic              ss_prev, sclk_prev;
  logic              sck_rise, sck_fall;
  logic [CNT_W-1:0]  cnt;
  logic [KEEP_W-1:0] shreg;
  logic [ADDR_W+1:0] stat_sr;
  logic              oe_q;

  assign frame_start = ss_prev & ~ss_s;
  assign frame_end   = ~ss_prev & ss_s;
  assign sck_rise    = ~ss_s & ~sclk_prev & sclk_s;
  assign sck_fall    = ~ss_s & sclk_prev & ~sclk_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      ss_prev   <= 1'b1;
      sclk_prev <= 1'b0;
      cnt       <= '0;
      shreg     <= '0;
      stat_sr   <= '0;
      oe_q      <= 1'b0;
    end else begin
      ss_prev   <= ss_s;
      sclk_prev <= sclk_s;
      oe_q      <= ~ss_s;
      if (frame_start) begin
        cnt     <= '0;
        shreg   <= '0;
        stat_sr <= status_in;
      end else begin
        if (sck_rise) begin
          if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
          if (cnt < KEEP_C) shreg[cnt[IDX_W-1:0]] <= mosi_s;
        end
        if (sck_fall)       stat_sr <= {1'b0, stat_sr[ADDR_W+1:1]};
        else if (frame_end) stat_sr <= '0;
      end
    end
  end

  assign frame_bits = shreg;
  assign frame_len  = cnt;
  assign miso       = stat_sr[0];
  assign miso_oe    = oe_q;

  // R1: bit counter frozen while deselected
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (ss_s && ss_prev) |=> $stable(cnt));
  // R8: status shifts only on a falling SCLK edge inside a frame
  a_r8_miso_stable: assert property (@(posedge clk) disable iff (rst)
    (!ss_s && !frame_start && !sck_fall) |=> $stable(miso));
endmodule

// File: rtl/vrec_decode.sv
module vrec_decode #(
  parameter int ADDR_W = 16,
  parameter int CTRL_W = 8,
  localparam int LONG_W = ADDR_W + CTRL_W,
  localparam int CNT_W  = $clog2(LONG_W) + 1,
  localparam int KEEP_W = ADDR_W + vrec_pkg::NCTRL
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_end,
  input  logic [KEEP_W-1:0] frame_bits,
  input  logic [CNT_W-1:0]  frame_len,
  output logic              cmd_valid,
  output logic [3:0]        cmd_kind,
  output logic              cmd_run,
  output logic              cmd_play,
  output logic              cmd_pwr,
  output logic              cmd_ign_addr,
  output logic              cmd_cue,
  output logic              cmd_has_addr,
  output logic [ADDR_W-1:0] cmd_addr
);
  import vrec_pkg::*;

  localparam logic [CNT_W-1:0] SHORT_C = CNT_W'(CTRL_W);
  localparam logic [CNT_W-1:0] LONG_C  = CNT_W'(LONG_W);

  logic      is_short, is_long;
  ctrl_t     c;
  cmd_kind_e k;
  logic      cue_ok;

  assign is_short = (frame_len == SHORT_C);
  assign is_long  = (frame_len == LONG_C);
  assign c = is_long ? ctrl_t'(frame_bits[ADDR_W +: NCTRL])
                     : ctrl_t'(frame_bits[NCTRL-1:0]);
  assign cue_ok = c.mc & c.run & c.pr & c.pu;

  always_comb begin
    casez ({c.run, c.pr, c.pu, c.iab, c.mc})
      5'b00100: k = K_PWRUP;
      5'b11100: k = K_SETPLAY;
      5'b11110: k = K_PLAY;
      5'b10100: k = K_SETREC;
      5'b10110: k = K_REC;
      5'b11101: k = K_SETCUE;
      5'b11111: k = K_CUE;
      5'b0?110: k = K_STOP;
      5'b0?01?: k = K_STOPPD;
      default:  k = K_OTHER;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid    <= 1'b0;
      cmd_kind     <= K_NONE;
      cmd_run      <= 1'b0;
      cmd_play     <= 1'b0;
      cmd_pwr      <= 1'b0;
      cmd_ign_addr <= 1'b0;
      cmd_cue      <= 1'b0;
      cmd_has_addr <= 1'b0;
      cmd_addr     <= '0;
    end else begin
      cmd_valid <= frame_end & (is_short | is_long);
      if (frame_end && (is_short || is_long)) begin
        cmd_kind     <= k;
        cmd_run      <= c.run;
        cmd_play     <= c.pr;
        cmd_pwr      <= c.pu;
        cmd_ign_addr <= c.iab;
        cmd_cue      <= cue_ok;
        cmd_has_addr <= is_long;
        cmd_addr     <= is_long ? frame_bits[ADDR_W-1:0] : '0;
      end
    end
  end

  // R7: strobe lasts exactly one cycle
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);
  // R6: cueing only on a running play
  a_r6_cue_play: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_cue) |-> (cmd_play && cmd_run && cmd_pwr));
  // R3: short frames carry no address
  a_r3_short_addr: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_has_addr) |-> (cmd_addr == '0));
endmodule

// File: rtl/vrec_intr.sv
module vrec_intr (
  input  logic clk,
  input  logic rst,
  input  logic evt_ovf,
  input  logic evt_eom,
  input  logic clr,
  output logic ovf_q,
  output logic eom_q,
  output logic int_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q <= 1'b0;
      eom_q <= 1'b0;
      int_n <= 1'b1;
    end else begin
      ovf_q <= evt_ovf | (ovf_q & ~clr);
      eom_q <= evt_eom | (eom_q & ~clr);
      int_n <= ~(evt_ovf | evt_eom | ((ovf_q | eom_q) & ~clr));
    end
  end

  // R10: an event pulls the line low next cycle
  a_r10_set: assert property (@(posedge clk) disable iff (rst)
    (evt_ovf || evt_eom) |=> !int_n);
  // R10: low persists until a frame starts
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!int_n && !clr) |=> !int_n);
  // R10: frame start releases when no new event
  a_r10_release: assert property (@(posedge clk) disable iff (rst)
    (clr && !evt_ovf && !evt_eom) |=> int_n);
endmodule

// File: rtl/vrec_cmd_slave.sv
module vrec_cmd_slave #(
  parameter int ADDR_W = 16,
  parameter int CTRL_W = 8,
  parameter int SYNC_STAGES = 2,
  localparam int LONG_W = ADDR_W + CTRL_W,
  localparam int CNT_W  = $clog2(LONG_W) + 1,
  localparam int KEEP_W = ADDR_W + vrec_pkg::NCTRL
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ss_n,
  input  logic              sclk,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  output logic              int_n,
  input  logic              evt_ovf,
  input  logic              evt_eom,
  input  logic [ADDR_W-1:0] row_ptr,
  output logic              cmd_valid,
  output logic [3:0]        cmd_kind,
  output logic              cmd_run,
  output logic              cmd_play,
  output logic              cmd_pwr,
  output logic              cmd_ign_addr,
  output logic              cmd_cue,
  output logic              cmd_has_addr,
  output logic [ADDR_W-1:0] cmd_addr
);
  logic [2:0]        pins_s;
  logic              ss_s, sclk_s, mosi_s;
  logic              frame_start, frame_end;
  logic [KEEP_W-1:0] frame_bits;
  logic [CNT_W-1:0]  frame_len;
  logic              ovf_q, eom_q;

  vrec_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d({ss_n, sclk, mosi}), .q(pins_s)
  );
  assign ss_s   = pins_s[2];
  assign sclk_s = pins_s[1];
  assign mosi_s = pins_s[0];

  vrec_frame #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) u_frame (
    .clk(clk), .rst(rst), .ss_s(ss_s), .sclk_s(sclk_s), .mosi_s(mosi_s),
    .status_in({row_ptr, eom_q, ovf_q}),
    .frame_start(frame_start), .frame_end(frame_end),
    .frame_bits(frame_bits), .frame_len(frame_len),
    .miso(miso), .miso_oe(miso_oe)
  );

  vrec_decode #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) u_decode (
    .clk(clk), .rst(rst), .frame_end(frame_end),
    .frame_bits(frame_bits), .frame_len(frame_len),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_run(cmd_run),
    .cmd_play(cmd_play), .cmd_pwr(cmd_pwr), .cmd_ign_addr(cmd_ign_addr),
    .cmd_cue(cmd_cue), .cmd_has_addr(cmd_has_addr), .cmd_addr(cmd_addr)
  );

  vrec_intr u_intr (
    .clk(clk), .rst(rst), .evt_ovf(evt_ovf), .evt_eom(evt_eom),
    .clr(frame_start), .ovf_q(ovf_q), .eom_q(eom_q), .int_n(int_n)
  );

  // R7: strobe appears only once select is back high
  a_r7_after_rise: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> ss_s);
  // R9: driver enabled only inside a frame
  a_r9_oe_frame: assert property (@(posedge clk) disable iff (rst)
    (ss_s && $past(ss_s)) |-> !miso_oe);
endmodule

// File: tb/vrec_cmd_slave_tb.sv
module vrec_cmd_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SCK_HALF   = 5 * CLK_PERIOD;

  logic clk, rst, ss_n, sclk, mosi, evt_ovf, evt_eom;
  logic [15:0] row_ptr;
  logic miso, miso_oe, int_n, cmd_valid;
  logic [3:0] cmd_kind;
  logic cmd_run, cmd_play, cmd_pwr, cmd_ign_addr, cmd_cue, cmd_has_addr;
  logic [15:0] cmd_addr;

  vrec_cmd_slave u_dut (
    .clk(clk), .rst(rst), .ss_n(ss_n), .sclk(sclk), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .int_n(int_n),
    .evt_ovf(evt_ovf), .evt_eom(evt_eom), .row_ptr(row_ptr),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_run(cmd_run),
    .cmd_play(cmd_play), .cmd_pwr(cmd_pwr), .cmd_ign_addr(cmd_ign_addr),
    .cmd_cue(cmd_cue), .cmd_has_addr(cmd_has_addr), .cmd_addr(cmd_addr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [3:0]  kind;
    logic        run, pr, pu, iab, cue, has;
    logic [15:0] addr;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int n_cmp = 0, n_bad = 0, n_valid = 0;
  logic last_int_seen, last_oe_seen;
  bit done = 0;

  task automatic chk(bit ok, string tag, string what, longint act, longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // monitor: pop expected strobes as they appear
  always @(negedge clk) begin
    if (!rst && cmd_valid) begin
      n_valid++;
      if (q.size() == 0) chk(0, "R4", "unexpected strobe", 1, 0);
      else begin
        e = q.pop_front();
        chk({cmd_kind, cmd_run, cmd_play, cmd_pwr, cmd_ign_addr, cmd_cue,
             cmd_has_addr, cmd_addr} ==
            {e.kind, e.run, e.pr, e.pu, e.iab, e.cue, e.has, e.addr},
            e.tag, "command fields",
            {cmd_kind, cmd_run, cmd_play, cmd_pwr, cmd_ign_addr, cmd_cue,
             cmd_has_addr, cmd_addr},
            {e.kind, e.run, e.pr, e.pu, e.iab, e.cue, e.has, e.addr});
      end
    end
  end

  task automatic frame(int nbits, logic [31:0] data, output logic [31:0] rx,
                       output int valid_during);
    int v0;
    v0 = n_valid;
    rx = '0;
    ss_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      mosi = data[i];
      #SCK_HALF;
      rx[i] = miso;
      if (i == 0) begin
        last_int_seen = int_n;
        last_oe_seen  = miso_oe;
      end
      sclk = 1'b1;
      #SCK_HALF;
      sclk = 1'b0;
    end
    #SCK_HALF;
    valid_during = n_valid - v0;
    ss_n = 1'b1;
    #(12 * CLK_PERIOD);
  endtask

  // op is written RUN PLAY PWR IAB CUE, most significant first
  task automatic send(int nbits, logic [4:0] op, logic [15:0] addr,
                      logic [3:0] kind, logic cue, string tag,
                      logic s_ovf, logic s_eom);
    logic [7:0]  cbyte;
    logic [31:0] data, rx, expv, mask;
    logic [17:0] stat;
    int vd;
    exp_t it;
    cbyte = {3'b101, op[0], op[1], op[2], op[3], op[4]};
    data  = (nbits == 8) ? {24'h0, cbyte} : {8'h0, cbyte, addr};
    if (nbits == 8 || nbits == 24) begin
      it.kind = kind; it.run = op[4]; it.pr = op[3]; it.pu = op[2];
      it.iab = op[1]; it.cue = cue; it.has = (nbits == 24);
      it.addr = (nbits == 24) ? addr : 16'h0; it.tag = tag;
      q.push_back(it);
    end
    stat = {row_ptr, s_eom, s_ovf};
    expv = {14'h0, stat};
    mask = (nbits >= 32) ? 32'hFFFF_FFFF : ((32'h1 << nbits) - 1);
    frame(nbits, data, rx, vd);
    chk(vd == 0, "R7", "strobe during frame", vd, 0);
    chk((rx & mask) == (expv & mask), "R8", "miso status bits", rx & mask, expv & mask);
    chk(last_oe_seen == 1'b1, "R9", "miso_oe in frame", last_oe_seen, 1);
  endtask

  initial begin
    #(150000 * CLK_PERIOD);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int v0;
    rst = 1'b1; ss_n = 1'b1; sclk = 1'b0; mosi = 1'b0;
    evt_ovf = 1'b0; evt_eom = 1'b0; row_ptr = 16'hA5C3;
    #2;
    #(5 * CLK_PERIOD);
    rst = 1'b0;
    #(3 * CLK_PERIOD);
    chk(int_n == 1'b1, "R11", "int_n after reset", int_n, 1);
    chk(miso_oe == 1'b0, "R11", "miso_oe after reset", miso_oe, 0);
    chk(miso == 1'b0, "R11", "miso after reset", miso, 0);
    chk(cmd_valid == 1'b0, "R11", "cmd_valid after reset", cmd_valid, 0);

    send(24, 5'b11100, 16'h1234, 4'd2,  1'b0, "R2", 0, 0);
    send(8,  5'b11110, 16'h0,    4'd3,  1'b0, "R3", 0, 0);
    send(24, 5'b10100, 16'hBEEF, 4'd4,  1'b0, "R5", 0, 0);
    send(8,  5'b10110, 16'h0,    4'd5,  1'b0, "R5", 0, 0);
    send(24, 5'b11101, 16'h0F0F, 4'd6,  1'b1, "R6", 0, 0);
    send(8,  5'b11111, 16'h0,    4'd7,  1'b1, "R6", 0, 0);
    send(8,  5'b00110, 16'h0,    4'd8,  1'b0, "R5", 0, 0);
    send(8,  5'b01110, 16'h0,    4'd8,  1'b0, "R5", 0, 0);
    send(8,  5'b00011, 16'h0,    4'd9,  1'b0, "R5", 0, 0);
    send(24, 5'b01010, 16'h8001, 4'd9,  1'b0, "R5", 0, 0);
    send(24, 5'b00100, 16'hFFFF, 4'd1,  1'b0, "R2", 0, 0);
    send(8,  5'b10101, 16'h0,    4'd15, 1'b0, "R6", 0, 0);
    send(24, 5'b10111, 16'h4321, 4'd15, 1'b0, "R6", 0, 0);

    // R4: malformed lengths
    v0 = n_valid;
    send(12, 5'b11100, 16'h5555, 4'd0, 1'b0, "R4", 0, 0);
    send(23, 5'b11100, 16'h5555, 4'd0, 1'b0, "R4", 0, 0);
    send(25, 5'b11100, 16'h5555, 4'd0, 1'b0, "R4", 0, 0);
    send(1,  5'b11100, 16'h5555, 4'd0, 1'b0, "R4", 0, 0);
    chk(n_valid == v0, "R4", "strobes for bad lengths", n_valid - v0, 0);

    // R1: SCLK activity while deselected
    v0 = n_valid;
    for (int i = 0; i < 10; i++) begin
      mosi = i[0]; sclk = 1'b1; #SCK_HALF; sclk = 1'b0; #SCK_HALF;
    end
    #(10 * CLK_PERIOD);
    chk(n_valid == v0, "R1", "strobe while deselected", n_valid - v0, 0);
    chk(miso_oe == 1'b0, "R1", "miso_oe while deselected", miso_oe, 0);
    send(8, 5'b11110, 16'h0, 4'd3, 1'b0, "R1", 0, 0);
    chk(miso_oe == 1'b0, "R9", "miso_oe after frame", miso_oe, 0);

    // R10: overflow event
    evt_ovf = 1'b1; #CLK_PERIOD; evt_ovf = 1'b0;
    #(3 * CLK_PERIOD);
    chk(int_n == 1'b0, "R10", "int_n after overflow", int_n, 0);
    #(20 * CLK_PERIOD);
    chk(int_n == 1'b0, "R10", "int_n held low", int_n, 0);
    row_ptr = 16'h0001;
    send(8, 5'b11110, 16'h0, 4'd3, 1'b0, "R8", 1, 0);
    chk(last_int_seen == 1'b1, "R10", "int_n released at frame start", last_int_seen, 1);
    chk(int_n == 1'b1, "R10", "int_n after frame", int_n, 1);

    // end-of-message event
    evt_eom = 1'b1; #CLK_PERIOD; evt_eom = 1'b0;
    #(3 * CLK_PERIOD);
    chk(int_n == 1'b0, "R10", "int_n after eom", int_n, 0);
    send(24, 5'b11100, 16'h00A0, 4'd2, 1'b0, "R8", 0, 1);
    chk(last_int_seen == 1'b1, "R10", "int_n released (eom)", last_int_seen, 1);

    // both flags, then cleared on the following frame
    evt_ovf = 1'b1; evt_eom = 1'b1; #CLK_PERIOD; evt_ovf = 1'b0; evt_eom = 1'b0;
    #(3 * CLK_PERIOD);
    row_ptr = 16'hFFFE;
    send(24, 5'b10110, 16'h7777, 4'd5, 1'b0, "R8", 1, 1);
    send(8,  5'b00110, 16'h0,    4'd8, 1'b0, "R8", 0, 0);

    #(20 * CLK_PERIOD);
    chk(q.size() == 0, "R4", "pending expected strobes", q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule